// File: doc/BRIEF.md
# Variable Page Size Translation Lookaside Buffer

This block is a 64-entry, fully associative address translation cache that software alone fills and maintains. Each entry holds a tag word, which gives an effective page number, a page-size code and a valid flag, and a 32-bit data word, which gives a real page number, execute and write permission bits, a zone number and four storage attribute bits. Every entry carries its own page size, from 1 KB to 16 MB in steps of four. The page size sets how many effective-address bits take part in the tag compare and how many low address bits pass through untranslated.

Software uses a register-style access port. On that port it can read or write either word of any entry by index, search by effective address to get back the lowest matching index, invalidate every entry that matches an address, or invalidate the whole array in one cycle. A separate lookup port takes a 32-bit effective address every cycle and returns the registered translation one cycle later. The result is the physical address, the permissions, the zone and the attributes, or a miss flag.

Top module: `vps_tlb`

## Requirements
- R1: Any entry 0..63 can be written and read through the access port. `acc_sel`=0 selects the tag word and `acc_sel`=1 selects the data word. Read data appears on `acc_rdata` the cycle after a read is issued and holds until the next read. A tag read returns bits 31..10 effective page number, bits 9..7 page-size code, bit 6 valid and bits 5..0 as zero.
- R2: A page-size code n (0..7) gives a page of 1 KB times 4^n. The tag compare ignores effective-address bits below bit 10+2n and compares bits 31 down to 10+2n against the same bits of the effective page number.
- R3: On a hit, `lk_pa` takes bits 31 down to 10+2n from the real page number (data bits 31..10) and the bits below from the effective address. `lk_ex` is data bit 9, `lk_wr` is data bit 8, `lk_zone` is data bits 7..4 and `lk_attr` is data bits 3..0, ordered write-through, cache-inhibited, coherent, guarded from bit 3 down to bit 0.
- R4: Only an entry whose valid bit is set can hit. When several valid entries match, the lowest index wins, for lookup and for search alike.
- R5: On a lookup miss, `lk_miss` is 1 and `lk_pa`, `lk_ex`, `lk_wr`, `lk_zone` and `lk_attr` are all zero.
- R6: The lookup result for the address presented in one cycle appears after the next clock edge. A tag write takes effect for lookups presented in the cycle after the write.
- R7: A search (`srch_en`) returns `srch_hit` and the 6-bit `srch_idx` in the next cycle. `srch_idx` is 0 on a miss, and both outputs hold while no search is issued.
- R8: Invalidate-by-address (`inv_en` with `srch_ea`) clears the valid bit of every entry that matches the address, whatever its index.
- R9: `inv_all` clears every valid bit in one cycle and takes precedence over an access-port write or an address invalidate in the same cycle.
- R10: Synchronous active-low reset clears all entries, so every lookup and search misses and every read returns zero until entries are written.
- R11: Index 63 and every low index are written directly with no reserved or skipped slot, and entry 63 translates like any other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access port operation valid |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = tag word, 1 = data word |
| acc_idx | input | 6 | Entry index |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| srch_en | input | 1 | Search by `srch_ea` |
| inv_en | input | 1 | Invalidate entries matching `srch_ea` |
| inv_all | input | 1 | Invalidate every entry |
| srch_ea | input | 32 | Effective address for search and invalidate |
| srch_hit | output | 1 | Search found a valid match |
| srch_idx | output | 6 | Lowest matching index, 0 on miss |
| lk_ea | input | 32 | Lookup effective address |
| lk_pa | output | 32 | Translated physical address |
| lk_ex | output | 1 | Execute permitted |
| lk_wr | output | 1 | Write permitted |
| lk_zone | output | 4 | Zone select |
| lk_attr | output | 4 | Storage attributes W, I, M, G |
| lk_miss | output | 1 | No valid entry matched |

## Verification
On every cycle the assertions check that a miss zeroes all translation outputs and that a search miss reports index zero. They also check that read data and search results hold when no operation is issued, that tag reads return zero in the low six bits, and that a full invalidate leaves the lookup and search ports reporting misses two edges later. The bench scenarios show what depends on data values. These are the translated address and its page-size masking at both edges of every page size, lowest-index priority, invalidation of all matching entries, write-to-lookup visibility, and full invalidate winning over a same-cycle write.

// File: rtl/tlb_pkg.sv
// Package: shared sizes, entry types and the page mask helper for the TLB.
// Assumes 32-bit addresses and a fixed 1 KB minimum page.
package tlb_pkg;
    localparam int ADDR_W  = 32;
    localparam int PAGE_LSB = 10;
    localparam int PN_W    = ADDR_W - PAGE_LSB;
    localparam int PSZ_W   = 3;

    typedef struct packed {
        logic [PN_W-1:0]  epn;
        logic [PSZ_W-1:0] psz;
        logic             vld;
    } tag_t;

    // Mask of page-number bits that take part in the compare for a size code.
    function automatic logic [PN_W-1:0] pn_mask(input logic [PSZ_W-1:0] psz);
        logic [PN_W-1:0] one;
        one = {{(PN_W-1){1'b0}}, 1'b1};
        return ~((one << (2 * psz)) - one);
    endfunction
endpackage

// File: rtl/tlb_match.sv
// Module: parallel compare of one effective address against every entry tag.
// Assumes tags arrive from flops; the output is purely combinational.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 64
) (
    input  logic [ADDR_W-1:0] ea,
    input  tag_t              tags [N],
    output logic [N-1:0]      hits
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [PN_W-1:0] m;
        // Masked page-number compare, gated by the valid flag.
        always_comb begin
            m       = pn_mask(tags[g].psz);
            hits[g] = tags[g].vld &&
                      (((ea[ADDR_W-1:PAGE_LSB] ^ tags[g].epn) & m) == '0);
        end
    end
endmodule

// File: rtl/tlb_prio.sv
// Module: lowest-index-first priority encoder over a hit vector.
// Assumes N is a power of two; index is zero when no bit is set.
module tlb_prio #(
    parameter int N  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the final assignment.
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vps_tlb.sv
// Module: 64-entry software-managed TLB with a per-entry page size.
// Holds tag and data words in flops, one matcher for the lookup port and one
// shared by search and invalidate-by-address. Assumes at most one access-port
// operation per cycle; inv_all overrides any same-cycle update.
module vps_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic              acc_sel,
    input  logic [IW-1:0]     acc_idx,
    input  logic [ADDR_W-1:0] acc_wdata,
    output logic [ADDR_W-1:0] acc_rdata,
    input  logic              srch_en,
    input  logic              inv_en,
    input  logic              inv_all,
    input  logic [ADDR_W-1:0] srch_ea,
    output logic              srch_hit,
    output logic [IW-1:0]     srch_idx,
    input  logic [ADDR_W-1:0] lk_ea,
    output logic [ADDR_W-1:0] lk_pa,
    output logic              lk_ex,
    output logic              lk_wr,
    output logic [3:0]        lk_zone,
    output logic [3:0]        lk_attr,
    output logic              lk_miss
);
    tag_t              tags  [ENTRIES];
    logic [ADDR_W-1:0] datas [ENTRIES];

    logic [ENTRIES-1:0] lk_hits, sr_hits;
    logic               lk_any, sr_any;
    logic [IW-1:0]      lk_sel, sr_sel;

    tlb_match #(.N(ENTRIES)) u_lk_match (.ea(lk_ea),   .tags(tags), .hits(lk_hits));
    tlb_match #(.N(ENTRIES)) u_sr_match (.ea(srch_ea), .tags(tags), .hits(sr_hits));
    tlb_prio  #(.N(ENTRIES)) u_lk_prio  (.hits(lk_hits), .any(lk_any), .idx(lk_sel));
    tlb_prio  #(.N(ENTRIES)) u_sr_prio  (.hits(sr_hits), .any(sr_any), .idx(sr_sel));

    // Storage update: writes, then address invalidate, then full invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags[i]  <= '0;
                datas[i] <= '0;
            end
        end else begin
            if (acc_en && acc_we) begin
                if (acc_sel) datas[acc_idx] <= acc_wdata;
                else         tags[acc_idx]  <= tag_t'(acc_wdata[ADDR_W-1:6]);
            end
            if (inv_en) begin
                for (int i = 0; i < ENTRIES; i++)
                    if (sr_hits[i]) tags[i].vld <= 1'b0;
            end
            if (inv_all) begin
                for (int i = 0; i < ENTRIES; i++) tags[i].vld <= 1'b0;
            end
        end
    end

    // Registered read port; holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                 acc_rdata <= '0;
        else if (acc_en && !acc_we) acc_rdata <= acc_sel ? datas[acc_idx]
                                                         : {tags[acc_idx], 6'b0};
    end

    // Registered search result; holds between searches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srch_hit <= 1'b0;
            srch_idx <= '0;
        end else if (srch_en) begin
            srch_hit <= sr_any;
            srch_idx <= sr_sel;
        end
    end

    logic [ADDR_W-1:0] sel_data;
    logic [PN_W-1:0]   sel_mask;
    // Pick the winning entry and splice real and effective page bits.
    always_comb begin
        sel_data = datas[lk_sel];
        sel_mask = pn_mask(tags[lk_sel].psz);
    end

    // Registered lookup result, zeroed on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n || !lk_any) begin
            lk_pa   <= '0;
            lk_ex   <= 1'b0;
            lk_wr   <= 1'b0;
            lk_zone <= '0;
            lk_attr <= '0;
            lk_miss <= rst_n;
        end else begin
            lk_pa   <= {(sel_data[ADDR_W-1:PAGE_LSB] & sel_mask) |
                        (lk_ea[ADDR_W-1:PAGE_LSB] & ~sel_mask),
                        lk_ea[PAGE_LSB-1:0]};
            lk_ex   <= sel_data[9];
            lk_wr   <= sel_data[8];
            lk_zone <= sel_data[7:4];
            lk_attr <= sel_data[3:0];
            lk_miss <= 1'b0;
        end
    end
endmodule

// File: rtl/vps_tlb_chk.sv
// Module: assertion checker bound to vps_tlb; observes ports only.
module vps_tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_we,
    input logic        acc_sel,
    input logic [31:0] acc_rdata,
    input logic        srch_en,
    input logic        inv_all,
    input logic        srch_hit,
    input logic [5:0]  srch_idx,
    input logic [31:0] lk_pa,
    input logic        lk_ex,
    input logic        lk_wr,
    input logic [3:0]  lk_zone,
    input logic [3:0]  lk_attr,
    input logic        lk_miss
);
    logic seen1, seen2;
    // Track cycles since reset so $past never reaches before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen1 <= 1'b0;
            seen2 <= 1'b0;
        end else begin
            seen1 <= 1'b1;
            seen2 <= seen1;
        end
    end

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_pa == 0 && !lk_ex && !lk_wr && lk_zone == 0 && lk_attr == 0)); // R5
    AST_SRCH_MISS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_hit |-> srch_idx == 0); // R7
    AST_SRCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen1 && !srch_en) |=> ($stable(srch_hit) && $stable(srch_idx))); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen1 && !(acc_en && !acc_we)) |=> $stable(acc_rdata)); // R1
    AST_TAG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && !acc_sel) |=> acc_rdata[5:0] == 0); // R1
    AST_INVALL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen2 && $past(inv_all, 2)) |-> lk_miss); // R9
    AST_INVALL_SRCH: assert property (@(posedge clk) disable iff (!rst_n)
        (seen2 && $past(inv_all, 2) && $past(srch_en)) |-> !srch_hit); // R9
endmodule

bind vps_tlb vps_tlb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we), .acc_sel(acc_sel),
    .acc_rdata(acc_rdata), .srch_en(srch_en), .inv_all(inv_all),
    .srch_hit(srch_hit), .srch_idx(srch_idx), .lk_pa(lk_pa), .lk_ex(lk_ex),
    .lk_wr(lk_wr), .lk_zone(lk_zone), .lk_attr(lk_attr), .lk_miss(lk_miss)
);

// File: tb/sim_vps_tlb.sv
// Scoreboard bench: driver tasks push expectations computed from a model
// built on the requirements; a monitor pops and compares after each edge.
module sim_vps_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 0, acc_we = 0, acc_sel = 0;
    logic [5:0]  acc_idx = 0;
    logic [31:0] acc_wdata = 0, acc_rdata;
    logic        srch_en = 0, inv_en = 0, inv_all = 0;
    logic [31:0] srch_ea = 0;
    logic        srch_hit;
    logic [5:0]  srch_idx;
    logic [31:0] lk_ea = 0, lk_pa;
    logic        lk_ex, lk_wr, lk_miss;
    logic [3:0]  lk_zone, lk_attr;

    always #5 clk = ~clk;

    vps_tlb u0 (.*);

    typedef struct {
        int          kind;   // 0 lookup, 1 search, 2 read
        logic [31:0] v32;
        logic        flag;
        logic [5:0]  idx;
        logic [9:0]  perm;
        string       req;
    } item_t;
    item_t q[$];

    int applied = 0, bad = 0;
    bit done = 0;

    logic [31:0] m_tag [64];
    logic [31:0] m_dat [64];

    // Reference: compare bits 31 down to 10+2n for a valid entry.
    function automatic bit m_match(int i, logic [31:0] ea);
        logic [31:0] msk;
        msk = 32'hFFFF_FFFF << (10 + 2 * int'(m_tag[i][9:7]));
        return m_tag[i][6] && (((ea ^ m_tag[i]) & msk) == 0);
    endfunction

    function automatic int m_first(logic [31:0] ea);
        for (int i = 0; i < 64; i++) if (m_match(i, ea)) return i;
        return -1;
    endfunction

    task automatic idle();
        acc_en = 0; acc_we = 0; srch_en = 0; inv_en = 0; inv_all = 0;
    endtask

    task automatic wr(int idx, bit sel, logic [31:0] d);
        @(negedge clk); idle();
        acc_en = 1; acc_we = 1; acc_sel = sel; acc_idx = 6'(idx); acc_wdata = d;
        if (sel) m_dat[idx] = d; else m_tag[idx] = {d[31:6], 6'b0};
    endtask

    task automatic rd(int idx, bit sel, string req);
        item_t it;
        @(negedge clk); idle();
        acc_en = 1; acc_we = 0; acc_sel = sel; acc_idx = 6'(idx);
        it.kind = 2; it.v32 = sel ? m_dat[idx] : m_tag[idx]; it.req = req;
        it.flag = 0; it.idx = 0; it.perm = 0;
        q.push_back(it);
    endtask

    task automatic look(logic [31:0] ea, string req);
        item_t it;
        int w;
        logic [31:0] msk;
        @(negedge clk); idle();
        lk_ea = ea;
        w = m_first(ea);
        it.kind = 1 - 1; it.req = req; it.idx = 0;
        if (w < 0) begin
            it.flag = 1; it.v32 = 0; it.perm = 0;
        end else begin
            msk = 32'hFFFF_FFFF << (10 + 2 * int'(m_tag[w][9:7]));
            it.flag = 0;
            it.v32  = (m_dat[w] & msk) | (ea & ~msk);
            it.perm = m_dat[w][9:0];
        end
        q.push_back(it);
    endtask

    task automatic srch(logic [31:0] ea, string req);
        item_t it;
        int w;
        @(negedge clk); idle();
        srch_en = 1; srch_ea = ea;
        w = m_first(ea);
        it.kind = 1; it.req = req; it.v32 = 0; it.perm = 0;
        it.flag = (w >= 0); it.idx = (w >= 0) ? 6'(w) : 6'd0;
        q.push_back(it);
    endtask

    task automatic inv_addr(logic [31:0] ea);
        @(negedge clk); idle();
        inv_en = 1; srch_ea = ea;
        for (int i = 0; i < 64; i++) if (m_match(i, ea)) m_tag[i][6] = 1'b0;
    endtask

    // Monitor: compare every pending expectation after the capturing edge.
    always @(posedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            applied++;
            if (it.kind == 0) begin
                if (lk_miss !== it.flag || lk_pa !== it.v32 ||
                    {lk_ex, lk_wr, lk_zone, lk_attr} !== it.perm) begin
                    bad++;
                    $display("FAIL %s lookup: miss=%0b pa=%h perm=%h expected miss=%0b pa=%h perm=%h",
                             it.req, lk_miss, lk_pa, {lk_ex, lk_wr, lk_zone, lk_attr},
                             it.flag, it.v32, it.perm);
                end
            end else if (it.kind == 1) begin
                if (srch_hit !== it.flag || srch_idx !== it.idx) begin
                    bad++;
                    $display("FAIL %s search: hit=%0b idx=%0d expected hit=%0b idx=%0d",
                             it.req, srch_hit, srch_idx, it.flag, it.idx);
                end
            end else begin
                if (acc_rdata !== it.v32) begin
                    bad++;
                    $display("FAIL %s read: got %h expected %h", it.req, acc_rdata, it.v32);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] base, psz_b;
        for (int i = 0; i < 64; i++) begin m_tag[i] = 0; m_dat[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state
        rd(0, 0, "R10");
        rd(63, 1, "R10");
        look(32'h0000_0000, "R10");
        srch(32'h0000_0000, "R10");
        // R2 R3: one entry per size code, checked at both page edges
        for (int n = 0; n < 8; n++) begin
            base  = 32'(n) << 29;
            psz_b = 32'd1 << (10 + 2 * n);
            wr(n, 1, (32'h5A5A_5C00 ^ (32'(n) << 24)) | 32'h3FF & (32'h155 + 32'(n)));
            wr(n, 0, base | (32'(n) << 7) | 32'h40 | 32'h2F);
            look(base, "R2");
            look(base + psz_b - 1, "R3");
            look(base + psz_b, "R2");
            look(base - 1, "R2");
            look(base + (psz_b >> 1) + 32'h13, "R3");
        end
        // R1: tag readback with low bits zero, data readback
        rd(3, 0, "R1");
        rd(5, 1, "R1");
        // R6: tag write visible to the very next lookup
        wr(40, 1, 32'hCAFE_0B6D);
        wr(40, 0, 32'h1234_5000 | 32'h40);
        look(32'h1234_5155, "R6");
        // R4: lowest index wins; invalid entries never hit
        wr(20, 1, 32'hAAAA_A3F1);
        wr(20, 0, 32'h7770_0000 | (32'd2 << 7) | 32'h40);
        wr(10, 1, 32'hBBBB_B2E2);
        wr(10, 0, 32'h7770_0000 | (32'd3 << 7) | 32'h40);
        wr(5, 0, 32'h7770_0000 | (32'd3 << 7));
        look(32'h7770_0ABC, "R4");
        srch(32'h7770_0ABC, "R4");
        // R11 R7: index 63 usable; search hit and miss
        wr(63, 1, 32'h0F00_0FFF);
        wr(63, 0, 32'h9000_0000 | (32'd1 << 7) | 32'h40);
        look(32'h9000_0FFF, "R11");
        srch(32'h9000_0004, "R7");
        srch(32'hFFFF_FFF0, "R7");
        rd(63, 0, "R11");
        // R8: address invalidate clears every matching entry
        inv_addr(32'h7770_0010);
        look(32'h7770_0ABC, "R8");
        srch(32'h7770_0ABC, "R8");
        look(32'h9000_0FFF, "R8");
        // R9: full invalidate wins over a same-cycle write
        @(negedge clk); idle();
        inv_all = 1; acc_en = 1; acc_we = 1; acc_sel = 0; acc_idx = 6'd30;
        acc_wdata = 32'h3330_0000 | 32'h40;
        m_tag[30] = 32'h3330_0000 | 32'h40;
        for (int i = 0; i < 64; i++) m_tag[i][6] = 1'b0;
        look(32'h3330_0000, "R9");
        look(32'h9000_0FFF, "R9");
        srch(32'h0000_0000, "R9");
        rd(30, 0, "R9");
        @(negedge clk); idle();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule